// File: doc/BRIEF.md
# Serial Control Register Port

This block is a synchronous serial slave that gives a host read and write access to a small bank of 12-bit control registers. It makes its own bit clock by dividing the system clock by sixteen and presents that clock on a pin. The host drives an enable line and a data line aligned to that clock. The block drives back a ready strobe, a data line and that data line's output enable.

A transfer is a 16-bit frame sent least significant bit first. The frame carries a direction flag, a 3-bit register address and a 12-bit payload. A write frame stores its payload when the last bit arrives. A read frame causes a one-period ready strobe and then a 16-bit reply frame. The reply repeats the read flag and the address ahead of the register contents. The current value of every register is also brought out as a flat bus, so the logic the registers control can use it.

Top module: `ctl_serial_port`

## Requirements
- R1: `ser_sclk` is the system clock divided by DIV (16): it stays low for 8 clock cycles and then high for 8, and it is low after reset.
- R2: A frame starts only when `ser_en` is high at a rising edge of `ser_sclk` while the port is idle. The 16 rising edges that follow capture frame bits 0 to 15 from `ser_din`. While `ser_en` is low, `ser_din` has no effect.
- R3: Frame layout: bit 0 is the direction (1 = read, 0 = write). Bits 1 to 3 are the address, least significant bit first. Bits 4 to 15 are payload bits 0 to 11.
- R4: A write to address a (1 to 7) stores the payload in register a once bit 15 has been captured. Register a appears on `regs_flat[12*a-1 : 12*(a-1)]`.
- R5: A write to address 0 changes no register. A read of address 0 returns a zero payload.
- R6: A read frame leaves every register unchanged, whatever its payload bits hold.
- R7: After the rising edge that captures bit 15 of a read, `ser_ready` goes high at the next falling edge of `ser_sclk` and stays high for exactly one serial period. It never goes high for a write frame or for an aborted frame.
- R8: On the falling edge that ends the ready strobe, the reply starts and is shifted out one bit per serial period, least significant bit first. Reply bit 0 is 1, bits 1 to 3 are the address that was read, and bits 4 to 15 are the register contents. `ser_dout` changes only on falling edges of `ser_sclk`.
- R9: `ser_oe` is low in every clock cycle that follows a cycle with `ser_en` low. It is high only while the ready strobe or the reply is being driven.
- R10: If `ser_en` is low at any of the 16 capturing rising edges, the frame is dropped: no register changes and no ready strobe follows.
- R11: After reset all registers read zero, and `ser_ready`, `ser_oe` and `ser_dout` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Transfer enable from the host, sampled on serial rising edges |
| ser_din | input | 1 | Serial frame data from the host |
| ser_sclk | output | 1 | Generated serial bit clock |
| ser_dout | output | 1 | Serial reply data |
| ser_oe | output | 1 | Output enable for `ser_dout`; low means the pin floats |
| ser_ready | output | 1 | One-period strobe that announces a reply |
| regs_flat | output | 84 | Contents of registers 1 to 7, register 1 in the low bits |

## Verification
The assertions assume that the host changes `ser_en` and `ser_din` only away from the serial rising edge. They also assume that during a read the host holds `ser_en` high until it has sampled the last reply bit. The bench changes its inputs just after each falling edge of `ser_sclk` and reads the outputs just after each rising edge. On a read it lowers the enable line only after it has taken reply bit 15. The bench never starts a new frame while a reply is still running.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {RX_IDLE, RX_CAPTURE} rx_state_t;
  typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_READY, TX_SHIFT} tx_state_t;
endpackage

// File: rtl/sp_sclk_gen.sv
module sp_sclk_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic rise_tick,
  output logic fall_tick,
  output logic sclk
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;

  assign rise_tick = (cnt == CW'(HALF - 1));
  assign fall_tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + 1'b1;
      if (rise_tick)      sclk <= 1'b1;
      else if (fall_tick) sclk <= 1'b0;
    end
  end

  assert_rise_from_low_R1: assert property (@(posedge clk) disable iff (rst)
    rise_tick |-> !sclk);
  assert_fall_from_high_R1: assert property (@(posedge clk) disable iff (rst)
    fall_tick |-> sclk);
endmodule

// File: rtl/sp_frame_rx.sv
module sp_frame_rx
  import sp_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_tick,
  input  logic          en,
  input  logic          din,
  input  logic          busy,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int FW = 1 + AW + DW;
  localparam int IW = $clog2(FW);

  rx_state_t     state;
  logic [IW-1:0] idx;
  logic [FW-2:0] shreg;
  logic [FW-1:0] frame;

  assign frame = {din, shreg};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RX_IDLE;
      idx    <= '0;
      shreg  <= '0;
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      addr   <= '0;
      data   <= '0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (rise_tick) begin
        case (state)
          RX_IDLE: begin
            if (en && !busy) begin
              state <= RX_CAPTURE;
              idx   <= '0;
            end
          end
          default: begin
            if (!en) begin
              state <= RX_IDLE;
            end else if (idx == IW'(FW - 1)) begin
              wr_stb <= ~frame[0];
              rd_stb <= frame[0];
              addr   <= frame[AW:1];
              data   <= frame[FW-1:AW+1];
              state  <= RX_IDLE;
            end else begin
              shreg[idx] <= din;
              idx        <= idx + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assert_frame_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || rd_stb) |-> ($past(en) && $past(rise_tick)));
  assert_no_start_while_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |-> !$past(busy));
endmodule

// File: rtl/sp_reg_file.sv
module sp_reg_file #(
  parameter int NREG = 7,
  parameter int AW   = 3,
  parameter int DW   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] q_flat
);
  logic [DW-1:0] mem [NREG];
  logic [AW-1:0] slot;
  logic          hit;

  assign slot = addr - AW'(1);
  assign hit  = (addr != '0) && (int'(addr) <= NREG);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en && hit) begin
      mem[slot] <= wdata;
    end
  end

  assign rdata = hit ? mem[slot] : '0;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign q_flat[g*DW +: DW] = mem[g];
  end

  assert_addr0_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0) |=> $stable(q_flat));
  assert_regs_change_only_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q_flat));
endmodule

// File: rtl/sp_reply_tx.sv
module sp_reply_tx
  import sp_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_tick,
  input  logic          en,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          ready,
  output logic          dout,
  output logic          oe
);
  localparam int FW = 1 + AW + DW;
  localparam int IW = $clog2(FW);

  tx_state_t     state;
  logic [FW-1:0] word;
  logic [IW-1:0] idx;
  logic [IW-1:0] nidx;

  assign busy = (state != TX_IDLE);
  assign nidx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      word  <= '0;
      idx   <= '0;
      ready <= 1'b0;
      dout  <= 1'b0;
      oe    <= 1'b0;
    end else begin
      oe <= en && (state == TX_READY || state == TX_SHIFT);
      case (state)
        TX_IDLE: begin
          if (rd_stb) begin
            word  <= {rd_data, rd_addr, 1'b1};
            state <= TX_ARM;
          end
        end
        TX_ARM: begin
          if (fall_tick) begin
            ready <= 1'b1;
            state <= TX_READY;
          end
        end
        TX_READY: begin
          if (fall_tick) begin
            ready <= 1'b0;
            dout  <= word[0];
            idx   <= '0;
            state <= TX_SHIFT;
          end
        end
        default: begin
          if (fall_tick) begin
            if (idx == IW'(FW - 1)) begin
              dout  <= 1'b0;
              state <= TX_IDLE;
            end else begin
              dout <= word[nidx];
              idx  <= nidx;
            end
          end
        end
      endcase
    end
  end

  assert_oe_off_without_enable_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !oe);
  assert_dout_moves_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> $past(fall_tick));
  assert_ready_edges_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(ready) || $fell(ready)) |-> $past(fall_tick));
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port #(
  parameter int DIV  = 16,
  parameter int NREG = 7,
  parameter int AW   = 3,
  parameter int DW   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_en,
  input  logic               ser_din,
  output logic               ser_sclk,
  output logic               ser_dout,
  output logic               ser_oe,
  output logic               ser_ready,
  output logic [NREG*DW-1:0] regs_flat
);
  logic          rise_tick, fall_tick;
  logic          wr_stb, rd_stb, tx_busy;
  logic [AW-1:0] f_addr;
  logic [DW-1:0] f_data, rd_data;

  sp_sclk_gen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst(rst), .rise_tick(rise_tick), .fall_tick(fall_tick), .sclk(ser_sclk)
  );

  sp_frame_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .rise_tick(rise_tick), .en(ser_en), .din(ser_din),
    .busy(tx_busy), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(f_addr), .data(f_data)
  );

  sp_reg_file #(.NREG(NREG), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_stb), .addr(f_addr), .wdata(f_data),
    .rdata(rd_data), .q_flat(regs_flat)
  );

  sp_reply_tx #(.AW(AW), .DW(DW)) u_tx (
    .clk(clk), .rst(rst), .fall_tick(fall_tick), .en(ser_en), .rd_stb(rd_stb),
    .rd_addr(f_addr), .rd_data(rd_data), .busy(tx_busy), .ready(ser_ready),
    .dout(ser_dout), .oe(ser_oe)
  );

  assert_ready_only_for_read_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !tx_busy);
endmodule

// File: tb/ctl_serial_port_tb_top.sv
module ctl_serial_port_tb_top;
  localparam int NREG = 7;
  localparam int DW   = 12;

  logic clk = 0, rst = 1, ser_en = 0, ser_din = 0;
  logic ser_sclk, ser_dout, ser_oe, ser_ready;
  logic [NREG*DW-1:0] regs_flat;

  int checks = 0, errors = 0, cyc = 0, ready_seen = 0, reads_sent = 0;
  logic [DW-1:0] model [NREG+1];
  logic [15:0] exp_q [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  ctl_serial_port dut_i (
    .clk(clk), .rst(rst), .ser_en(ser_en), .ser_din(ser_din), .ser_sclk(ser_sclk),
    .ser_dout(ser_dout), .ser_oe(ser_oe), .ser_ready(ser_ready), .regs_flat(regs_flat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int a = 1; a <= NREG; a++)
      check(req, 32'(regs_flat[(a-1)*DW +: DW]), 32'(model[a]));
  endtask

  // abort_at < 0: full frame; otherwise enable drops before bit abort_at
  task automatic send(input bit rw, input logic [2:0] addr, input logic [DW-1:0] data,
                      input int abort_at);
    logic [15:0] fr = {data, addr, rw};
    @(negedge ser_sclk); #1 ser_en = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge ser_sclk); #1;
      if (i == abort_at) begin ser_en = 0; ser_din = 0; return; end
      ser_din = fr[i];
    end
    if (rw) begin
      reads_sent++;
      exp_q.push_back({(addr == 0) ? {DW{1'b0}} : model[addr], addr, 1'b1});
      repeat (18) @(posedge ser_sclk);
      #2 ser_en = 0; ser_din = 0;
    end else begin
      @(negedge ser_sclk); #1 ser_en = 0; ser_din = 0;
      if (addr != 0) model[addr] = data;
    end
  endtask

  // monitor: scoreboard of reply frames
  initial begin
    forever begin
      @(posedge ser_sclk); #1;
      if (ser_ready) begin
        logic [15:0] got;
        ready_seen++;
        for (int j = 0; j < 16; j++) begin
          @(posedge ser_sclk); #1;
          if (j == 0) check("R7 ready one period", 32'(ser_ready), 0);
          check("R9 oe during reply", 32'(ser_oe), 1);
          got[j] = ser_dout;
        end
        if (exp_q.size() == 0) check("R7 unexpected reply", 1, 0);
        else check("R8 reply frame", 32'(got), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0, t1, t2;
    for (int a = 0; a <= NREG; a++) model[a] = '0;
    repeat (3) @(posedge clk); #1;
    check("R11 regs reset", 32'(regs_flat == '0), 1);
    check("R11 ready reset", 32'(ser_ready), 0);
    check("R11 oe reset", 32'(ser_oe), 0);
    check("R11 dout reset", 32'(ser_dout), 0);
    check("R1 sclk reset", 32'(ser_sclk), 0);
    rst = 0;
    // R1: period and duty
    @(posedge ser_sclk); t0 = cyc;
    @(negedge ser_sclk); t1 = cyc;
    @(posedge ser_sclk); t2 = cyc;
    check("R1 high time", 32'(t1 - t0), 8);
    check("R1 period", 32'(t2 - t0), 16);
    // R2: data toggling with enable low does nothing
    for (int i = 0; i < 20; i++) begin @(negedge ser_sclk); #1 ser_din = i[0]; end
    ser_din = 0;
    check_regs("R2 idle din ignored");
    check("R7 no ready when idle", 32'(ready_seen), 0);
    // R3 R4: write every register with a distinct pattern
    for (int a = 1; a <= NREG; a++) begin
      send(0, 3'(a), 12'(12'h0A5 * a ^ 12'h813), -1);
      check_regs("R4 write stored");
      check("R9 oe low after write", 32'(ser_oe), 0);
    end
    check("R7 no ready on writes", 32'(ready_seen), 0);
    // R8: read back several registers
    send(1, 3'd1, 12'h000, -1);
    send(1, 3'd7, 12'h000, -1);
    send(1, 3'd4, 12'hFFF, -1);
    check_regs("R6 read leaves regs");
    // R5: address zero
    send(0, 3'd0, 12'hABC, -1);
    check_regs("R5 write addr0 ignored");
    send(1, 3'd0, 12'h5A5, -1);
    // R10: aborted frames
    send(0, 3'd2, 12'h3C3, 9);
    repeat (20) @(posedge ser_sclk);
    check_regs("R10 aborted write");
    send(1, 3'd3, 12'h000, 15);
    repeat (40) @(posedge ser_sclk);
    check("R10 no ready after abort", 32'(ready_seen), 32'(reads_sent));
    // R4 overwrite edges: all ones and all zeros
    send(0, 3'd7, 12'hFFF, -1);
    send(0, 3'd1, 12'h000, -1);
    check_regs("R4 overwrite");
    send(1, 3'd7, 12'h123, -1);
    send(1, 3'd1, 12'h000, -1);
    repeat (4) @(posedge ser_sclk); #1;
    check("R9 oe low when enable low", 32'(ser_oe), 0);
    check("R7 ready count", 32'(ready_seen), 32'(reads_sent));
    check("R8 all replies seen", 32'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule